// File: doc/BRIEF.md
# Word-Wide Stored-Program Processor

This block is a small 8-bit processor that runs a program held in its own instruction memory. Every instruction either performs one word-wide ALU operation between two of eight register slots and writes the result to a third slot, or it is a branch that copies a slot value into the program counter. There are no condition flags. A conditional jump is built in software: the program multiplies a 0/1 condition by one target address, multiplies its complement by the other, adds the two products and branches on the sum.

A host fills the instruction memory through a valid/ready load port while the `run` pin is low. It raises `run` to start execution from address 0 and waits for `halt`. A branch whose target value equals its own address is the stop instruction. Slot contents can be read at any time through a combinational debug port. The load port applies back-pressure: `prog_ready` is low whenever `run` is high. A word offered while `prog_ready` is low is not taken, and the source must hold it until a cycle in which both `prog_valid` and `prog_ready` are high.

Top module: `spc_core`

## Requirements
- R1: A synchronous active-high `rst` clears all eight slots to zero, sets the program counter to 0 and lowers `halt`. The instruction memory keeps its contents through reset.
- R2: `prog_ready` equals the inverse of `run`. A word is written to `prog_addr` on a clock edge where `prog_valid` and `prog_ready` are both high. Words offered while `run` is high leave the memory unchanged.
- R3: Instruction layout: bit 13 is the branch flag, bits 12:9 are the opcode, bits 8:6 are the first source slot, bits 5:3 are the second source slot and bits 2:0 are the destination slot.
- R4: Arithmetic opcodes: 0000 adds and 0010 subtracts (first source minus second), both modulo 256. 0110 multiplies and keeps the low 8 bits of the product.
- R5: Logic opcodes: 1000 is AND, 1010 is OR, 0100 is XOR, and 0001 is the bitwise complement of the first source.
- R6: Opcode 1110 shifts the first source left by one bit and opcode 1100 shifts it right by one bit. The vacated bit is filled with zero and the second source is ignored.
- R7: Any opcode not listed in R4 to R6 writes zero to the destination slot.
- R8: An executed non-branch instruction writes its result to the destination slot and advances the program counter by one, wrapping at the memory depth.
- R9: An executed branch loads the program counter with the low address bits of the first source slot and writes no slot. A target computed by multiplying a condition by candidate addresses and adding the products selects the correct path.
- R10: A branch whose first source value equals its own address raises `halt`. `halt` stays high until reset. No instruction executes while `halt` is high or `run` is low.
- R11: `dbg_data` shows the current contents of the slot selected by `dbg_sel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Execute when high; loading is allowed when low |
| prog_valid | input | 1 | Load port: a word is offered |
| prog_ready | output | 1 | Load port: the memory accepts a word |
| prog_addr | input | PC_W (6) | Load port: instruction memory address |
| prog_data | input | 14 | Load port: instruction word |
| dbg_sel | input | 3 | Debug port: slot to read |
| dbg_data | output | 8 | Debug port: contents of the selected slot |
| halt | output | 1 | A self-branch has been executed |

## Verification
The bench runs each ALU opcode on operands chosen so that a wrong operation shows up in the result. Subtraction is driven to wrap below zero, addition to wrap above 255, and the product to exceed 8 bits. A design that swapped the subtraction operands, sign-filled a shift, or let an unused opcode pass an operand through would leave a different byte in the destination slot. The conditional-jump program is run with the condition both true and false. A branch that wrote a slot or used the wrong source would land on the wrong path and stop at the wrong address. Further tests offer a word to the load port while the processor is running and check that rerunning the stored program gives the same result, confirm that nothing executes with `run` low, and confirm that slots stay frozen after `halt`.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int WORD_W  = 8;
  localparam int SLOT_N  = 8;
  localparam int SLOT_AW = $clog2(SLOT_N);
  localparam int OP_W    = 4;
  localparam int INSTR_W = 1 + OP_W + 3 * SLOT_AW;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'b0000,
    OP_INV = 4'b0001,
    OP_SUB = 4'b0010,
    OP_XOR = 4'b0100,
    OP_MUL = 4'b0110,
    OP_AND = 4'b1000,
    OP_OR  = 4'b1010,
    OP_SHR = 4'b1100,
    OP_SHL = 4'b1110
  } alu_op_e;

  typedef struct packed {
    logic               br;
    logic [OP_W-1:0]    op;
    logic [SLOT_AW-1:0] src1;
    logic [SLOT_AW-1:0] src2;
    logic [SLOT_AW-1:0] dst;
  } instr_t;
endpackage

// File: rtl/spc_alu.sv
module spc_alu
  import spc_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    y
);
  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MUL:  y = a * b;
      OP_INV:  y = ~a;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_SHL:  y = {a[W-2:0], 1'b0};
      OP_SHR:  y = {1'b0, a[W-1:1]};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/spc_slots.sv
module spc_slots #(
  parameter int N  = 8,
  parameter int W  = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd2,
  input  logic [AW-1:0] ra3,
  output logic [W-1:0]  rd3
);
  logic [W-1:0] slot_q [N];

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slot_q[i] <= '0;
      else if (we && (waddr == AW'(i)))
        slot_q[i] <= wdata;
    end
  end

  assign rd1 = slot_q[ra1];
  assign rd2 = slot_q[ra2];
  assign rd3 = slot_q[ra3];
endmodule

// File: rtl/spc_imem.sv
module spc_imem #(
  parameter int DEPTH = 64,
  parameter int IW    = 14,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  logic [IW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/spc_core.sv
module spc_core
  import spc_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  localparam int PC_W      = $clog2(IMEM_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               prog_valid,
  output logic               prog_ready,
  input  logic [PC_W-1:0]    prog_addr,
  input  logic [INSTR_W-1:0] prog_data,
  input  logic [SLOT_AW-1:0] dbg_sel,
  output logic [WORD_W-1:0]  dbg_data,
  output logic               halt
);
  logic [PC_W-1:0]    pc_q;
  logic               halt_q;
  logic [INSTR_W-1:0] fetch_word;
  instr_t             cur;
  logic [WORD_W-1:0]  opa, opb, alu_y;
  logic               exec_en, is_br, self_br, slot_we;

  assign prog_ready = !run;

  spc_imem #(.DEPTH(IMEM_DEPTH), .IW(INSTR_W)) imem_i (
    .clk   (clk),
    .we    (prog_valid && prog_ready),
    .waddr (prog_addr),
    .wdata (prog_data),
    .raddr (pc_q),
    .rdata (fetch_word)
  );

  assign cur     = instr_t'(fetch_word);
  assign is_br   = cur.br;
  assign exec_en = run && !halt_q;
  assign slot_we = exec_en && !is_br;
  assign self_br = (opa == WORD_W'(pc_q));

  spc_slots #(.N(SLOT_N), .W(WORD_W)) slots_i (
    .clk   (clk),
    .rst   (rst),
    .we    (slot_we),
    .waddr (cur.dst),
    .wdata (alu_y),
    .ra1   (cur.src1),
    .rd1   (opa),
    .ra2   (cur.src2),
    .rd2   (opb),
    .ra3   (dbg_sel),
    .rd3   (dbg_data)
  );

  spc_alu #(.W(WORD_W)) alu_i (
    .op (cur.op),
    .a  (opa),
    .b  (opb),
    .y  (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      halt_q <= 1'b0;
    end else if (exec_en) begin
      if (is_br) begin
        pc_q <= opa[PC_W-1:0];
        if (self_br)
          halt_q <= 1'b1;
      end else begin
        pc_q <= PC_W'(pc_q + 1'b1);
      end
    end
  end

  assign halt = halt_q;
endmodule

// File: rtl/spc_core_chk.sv
module spc_core_chk #(
  parameter int PC_W = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            run,
  input logic            halt,
  input logic [2:0]      dbg_sel,
  input logic [7:0]      dbg_data,
  input logic [PC_W-1:0] pc,
  input logic            exec_en,
  input logic            is_br,
  input logic [7:0]      opa
);
  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc == '0 && !halt));

  // R8
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_en && !is_br) |=> (pc == PC_W'($past(pc) + 1'b1)));

  // R9
  br_load_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_en && is_br) |=> (pc == $past(opa[PC_W-1:0])));

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);

  // R10
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> (!$stable(dbg_sel) || $stable(dbg_data)));

  // R10
  idle_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(pc) && (!$stable(dbg_sel) || $stable(dbg_data))));
endmodule

bind spc_core spc_core_chk #(.PC_W(PC_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .run      (run),
  .halt     (halt),
  .dbg_sel  (dbg_sel),
  .dbg_data (dbg_data),
  .pc       (pc_q),
  .exec_en  (exec_en),
  .is_br    (is_br),
  .opa      (opa)
);

// File: tb/spc_core_tb.sv
`timescale 1ns/1ps
module spc_core_tb_top;
  localparam int DEPTH = 64;
  localparam int PW    = $clog2(DEPTH);
  localparam int NVEC  = 12;
  // {opcode, first source, second source, expected}
  localparam logic [27:0] VEC [NVEC] = '{
    {4'b0000, 8'h18, 8'h14, 8'h2C},
    {4'b0100, 8'h18, 8'h14, 8'h0C},
    {4'b0010, 8'h18, 8'h14, 8'h04},
    {4'b0010, 8'h14, 8'h18, 8'hFC},
    {4'b0000, 8'hF0, 8'h20, 8'h10},
    {4'b0001, 8'h18, 8'h55, 8'hE7},
    {4'b1110, 8'h81, 8'hFF, 8'h02},
    {4'b1100, 8'h81, 8'hFF, 8'h40},
    {4'b1000, 8'hF0, 8'h3C, 8'h30},
    {4'b1010, 8'hF0, 8'h0F, 8'hFF},
    {4'b0110, 8'h13, 8'h11, 8'h43},
    {4'b0011, 8'h05, 8'h06, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        prog_valid = 1'b0;
  logic        prog_ready;
  logic [PW-1:0] prog_addr = '0;
  logic [13:0] prog_data = '0;
  logic [2:0]  dbg_sel = '0;
  logic [7:0]  dbg_data;
  logic        halt;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [13:0] pbuf [DEPTH];
  int n = 0;

  always #2 clk = ~clk;

  spc_core #(.IMEM_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .run(run),
    .prog_valid(prog_valid), .prog_ready(prog_ready),
    .prog_addr(prog_addr), .prog_data(prog_data),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data), .halt(halt)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      bad = bad + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 100000", cycles);
      $display("  test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [13:0] mk(input logic br, input logic [3:0] op,
                                     input logic [2:0] s1, input logic [2:0] s2,
                                     input logic [2:0] d);
    return {br, op, s1, s2, d};
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'b0000, 4'b0010, 4'b0110: return "R4";
      4'b1000, 4'b1010, 4'b0100, 4'b0001: return "R5";
      4'b1110, 4'b1100: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic emit(input logic [13:0] w);
    pbuf[n] = w;
    n = n + 1;
  endtask

  // slot 0 stays zero, slot 7 holds one, slot 6 holds 0xFF
  task automatic emit_init();
    n = 0;
    emit(mk(1'b0, 4'b0001, 3'd0, 3'd0, 3'd6));
    emit(mk(1'b0, 4'b0010, 3'd0, 3'd6, 3'd7));
  endtask

  task automatic build_const(input logic [2:0] s, input logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      emit(mk(1'b0, 4'b1110, s, 3'd0, s));
      emit(mk(1'b0, 4'b0000, s, v[i] ? 3'd7 : 3'd0, s));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    run = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load_prog();
    run = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      prog_valid = 1'b1;
      prog_addr  = PW'(i);
      prog_data  = pbuf[i];
    end
    @(negedge clk);
    prog_valid = 1'b0;
  endtask

  task automatic run_to_halt(input int max);
    @(negedge clk);
    run = 1'b1;
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (halt) break;
    end
  endtask

  task automatic read_slot(input logic [2:0] s, output logic [7:0] v);
    dbg_sel = s;
    #0.5;
    v = dbg_data;
  endtask

  task automatic cond_prog(input bit cond);
    emit_init();
    emit(mk(1'b0, 4'b0000, 3'd0, cond ? 3'd7 : 3'd0, 3'd1));
    emit(mk(1'b0, 4'b0010, 3'd7, 3'd1, 3'd2));
    build_const(3'd3, 8'd40);
    build_const(3'd4, 8'd42);
    emit(mk(1'b0, 4'b0110, 3'd1, 3'd3, 3'd3));
    emit(mk(1'b0, 4'b0110, 3'd2, 3'd4, 3'd4));
    emit(mk(1'b0, 4'b0000, 3'd3, 3'd4, 3'd5));
    emit(mk(1'b1, 4'b0000, 3'd5, 3'd0, 3'd0));
    emit(mk(1'b0, 4'b0000, 3'd5, 3'd7, 3'd5));
    emit(mk(1'b1, 4'b0000, 3'd5, 3'd0, 3'd0));
    emit(mk(1'b0, 4'b0000, 3'd5, 3'd7, 3'd5));
    emit(mk(1'b1, 4'b0000, 3'd5, 3'd0, 3'd0));
  endtask

  initial begin
    logic [7:0] v;
    do_reset();

    // reset state
    for (int s = 0; s < 8; s++) begin
      read_slot(3'(s), v);
      check("R1 slot cleared by reset (R11 read)", v, 8'h00);
    end
    check("R1 halt low after reset", {7'b0, halt}, 8'h00);
    check("R2 prog_ready with run low", {7'b0, prog_ready}, 8'h01);
    run = 1'b1;
    #0.5;
    check("R2 prog_ready with run high", {7'b0, prog_ready}, 8'h00);
    run = 1'b0;

    // opcode table, each run on the R3 layout and stopped by a self-branch
    for (int k = 0; k < NVEC; k++) begin
      do_reset();
      emit_init();
      build_const(3'd1, VEC[k][23:16]);
      build_const(3'd2, VEC[k][15:8]);
      emit(mk(1'b0, VEC[k][27:24], 3'd1, 3'd2, 3'd3));
      build_const(3'd5, 8'd51);
      emit(mk(1'b1, 4'b0000, 3'd5, 3'd0, 3'd0));
      load_prog();
      run_to_halt(200);
      check("R8 R10 program ran to its self-branch", {7'b0, halt}, 8'h01);
      read_slot(3'd3, v);
      check(tag_of(VEC[k][27:24]), v, VEC[k][7:0]);
    end

    // computed conditional branch, true path
    do_reset();
    cond_prog(1'b1);
    load_prog();
    run_to_halt(200);
    read_slot(3'd5, v);
    check("R9 condition true reaches first target", v, 8'd41);
    check("R10 halt on self-branch", {7'b0, halt}, 8'h01);

    // false path
    do_reset();
    cond_prog(1'b0);
    load_prog();
    run_to_halt(200);
    read_slot(3'd5, v);
    check("R9 condition false reaches second target", v, 8'd43);
    read_slot(3'd2, v);
    check("R11 debug read of complement slot", v, 8'h01);

    // halted core stays frozen
    repeat (10) @(negedge clk);
    read_slot(3'd5, v);
    check("R10 slots frozen after halt", v, 8'd43);
    check("R10 halt stays high", {7'b0, halt}, 8'h01);

    // offer a word while running: must not be written
    @(negedge clk);
    prog_valid = 1'b1;
    prog_addr  = PW'(2);
    prog_data  = mk(1'b0, 4'b0000, 3'd0, 3'd7, 3'd1);
    repeat (3) @(negedge clk);
    prog_valid = 1'b0;
    do_reset();
    check("R1 reset lowers halt", {7'b0, halt}, 8'h00);

    // run low: nothing executes
    repeat (20) @(negedge clk);
    read_slot(3'd6, v);
    check("R10 no execution while run is low", v, 8'h00);

    run_to_halt(200);
    read_slot(3'd5, v);
    check("R2 word offered while running was refused", v, 8'd43);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule